// File: doc/BRIEF.md
# Effective Address Generator

This block works out the operand address of one instruction for an 8-bit processor with a 16-bit address space. The control logic pulses a start input with a 4-bit mode code, the PC of the first operand byte (the byte after the opcode), the two index registers, a branch condition selector and the four condition flags. The block then reads the operand bytes, and any pointer bytes, through a single byte-wide read port. That port has a registered memory behind it, so data returns one cycle after the address. When the effective address and the updated PC are known, the block raises a valid strobe for one cycle.

It supports immediate, page-zero direct and page-zero indexed, full 16-bit direct and indexed, the pointer-based jump, pointer-before-index and pointer-after-index forms, and the signed relative branch. The pointer-based jump keeps the historical page-wrap behaviour: when the pointer ends at a page boundary, the high byte of the target is read from the start of the same 256-byte page. The block does not read the final operand and does not execute the instruction.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, `busy_o`, `valid_o` and `mem_rd_o` are 0.
- R2: `start_i` is accepted only while `busy_o` is 0. The block makes N memory reads, one per cycle, where N is 0 for codes 0 and 11-15, 1 for codes 1, 2, 3 and 10, 2 for codes 4-6, 3 for codes 8 and 9, and 4 for code 7. `valid_o` is high for exactly one cycle, N+1 cycles after the edge that accepted start. A start seen while busy is ignored, and the inputs captured at accept are held for the whole request.
- R3: Mode 0 (immediate): the address is the PC and the new PC is PC+1.
- R4: Modes 1, 2 and 3 (page zero, plain, +X and +Y): the block reads one operand byte at the PC, and the new PC is PC+1. The index is added modulo 256, so the upper address byte is always 0.
- R5: Modes 4, 5 and 6 (direct, plain, +X and +Y): the block reads the low byte at PC and the high byte at PC+1. The index is added with 16-bit wraparound, and the new PC is PC+2.
- R6: Mode 7 (pointer jump): the block reads a 16-bit pointer P at PC and PC+1. The target low byte comes from P. The target high byte comes from an address whose upper byte is P's upper byte and whose lower byte is (P low + 1) mod 256. The new PC is PC+2.
- R7: Mode 8 (pointer before index): Z = (operand + X) mod 256. The target low byte is read at Z and the high byte at Z+1 with 16-bit carry (0x00FF is followed by 0x0100). The new PC is PC+1.
- R8: Mode 9 (pointer after index): a 16-bit pointer is read at the page-zero operand address O, low byte at O and high byte at O+1 with 16-bit carry. The address is pointer + Y, modulo 65536. The new PC is PC+1.
- R9: Mode 10 (relative): the block reads a signed offset at PC. The address is PC+1+offset, and `taken_o` reports the condition. The new PC is that address when taken, else PC+1. `cond_i[2:1]` picks the flag (0 N, 1 V, 2 C, 3 Z), and `cond_i[0]` is the value required for taken. `flags_i` bits are [3] N, [2] V, [1] C, [0] Z. `taken_o` is 0 in all other modes.
- R10: Codes 11 to 15 are unused: the address and the new PC both equal the PC, and no read is made.
- R11: The read addresses appear on `mem_addr_o` with `mem_rd_o` high, in the order given in R4 to R9, and the operand is always read first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start_i | input | 1 | request strobe |
| mode_i | input | 4 | addressing mode code |
| pc_i | input | 16 | PC of first operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| cond_i | input | 3 | branch condition select |
| flags_i | input | 4 | N, V, C, Z flags |
| mem_rd_o | output | 1 | memory read request |
| mem_addr_o | output | 16 | memory read address |
| mem_rdata_i | input | 8 | read data, one cycle after the request |
| busy_o | output | 1 | request in progress |
| valid_o | output | 1 | result strobe |
| ea_o | output | 16 | effective address |
| pc_o | output | 16 | updated PC |
| taken_o | output | 1 | branch taken |

## Verification
Index sums are tried both below and across the 8-bit and 16-bit limits. Only the carry into the upper byte tells modulo-256 indexing apart from modulo-65536 indexing. The pointer jump is run once with a pointer low byte of 0xFF, where the page-wrap read gives a different target from a plain increment, and once with an ordinary pointer. Pointer-before-index is driven so that Z lands on 0xFF, which exposes whether the second pointer byte carries into page one. Branches cover all eight condition codes against flag patterns that make each one both true and false, with forward and backward offsets, so a swapped flag or an inverted polarity changes the result.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int MAX_RD = 4;
  localparam int STEP_W = $clog2(MAX_RD + 1);

  typedef logic [AW-1:0]     addr_t;
  typedef logic [DW-1:0]     byte_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam logic [3:0] MD_IMM   = 4'd0;
  localparam logic [3:0] MD_ZP    = 4'd1;
  localparam logic [3:0] MD_ZPX   = 4'd2;
  localparam logic [3:0] MD_ZPY   = 4'd3;
  localparam logic [3:0] MD_ABS   = 4'd4;
  localparam logic [3:0] MD_ABSX  = 4'd5;
  localparam logic [3:0] MD_ABSY  = 4'd6;
  localparam logic [3:0] MD_IND   = 4'd7;
  localparam logic [3:0] MD_PREX  = 4'd8;
  localparam logic [3:0] MD_POSTY = 4'd9;
  localparam logic [3:0] MD_REL   = 4'd10;

  typedef struct packed {
    addr_t ea;
    addr_t pc;
    logic  taken;
  } eag_res_t;

  // byte placed in page zero
  function automatic addr_t zp_of(byte_t b);
    return {{(AW-DW){1'b0}}, b};
  endfunction

  // unsigned widening of an index
  function automatic addr_t widen(byte_t b);
    return {{(AW-DW){1'b0}}, b};
  endfunction

  // signed widening of a branch offset
  function automatic addr_t sign_widen(byte_t b);
    return {{(AW-DW){b[DW-1]}}, b};
  endfunction

  // next byte address that never leaves the current page
  function automatic addr_t same_page_next(addr_t a);
    return {a[AW-1:DW], byte_t'(a[DW-1:0] + 1'b1)};
  endfunction

  // flag select in sel[2:1] (N, V, C, Z), wanted value in sel[0]
  function automatic logic branch_ok(logic [2:0] sel, logic [3:0] f);
    logic picked;
    case (sel[2:1])
      2'd0:    picked = f[3];
      2'd1:    picked = f[2];
      2'd2:    picked = f[1];
      default: picked = f[0];
    endcase
    return picked == sel[0];
  endfunction
endpackage

// File: rtl/eag_read_plan.sv
`timescale 1ns/1ps
module eag_read_plan
  import eag_pkg::*;
(
  input  logic [3:0] mode,
  output step_t      n_reads,
  output logic       zp_mode,
  output logic       unused_mode
);
  always_comb begin
    zp_mode     = 1'b0;
    unused_mode = 1'b0;
    case (mode)
      MD_IMM:                    n_reads = step_t'(0);
      MD_ZP, MD_ZPX, MD_ZPY: begin
        n_reads = step_t'(1);
        zp_mode = 1'b1;
      end
      MD_REL:                    n_reads = step_t'(1);
      MD_ABS, MD_ABSX, MD_ABSY:  n_reads = step_t'(2);
      MD_PREX, MD_POSTY:         n_reads = step_t'(3);
      MD_IND:                    n_reads = step_t'(MAX_RD);
      default: begin
        n_reads     = step_t'(0);
        unused_mode = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/eag_fetch_addr.sv
`timescale 1ns/1ps
module eag_fetch_addr
  import eag_pkg::*;
(
  input  logic [3:0] mode,
  input  step_t      step,
  input  addr_t      pc,
  input  byte_t      x,
  input  byte_t      v0,
  input  byte_t      v1,
  output addr_t      rd_addr
);
  addr_t zp_ptr;
  addr_t wide_ptr;
  logic  two_byte_operand;

  assign zp_ptr           = (mode == MD_PREX) ? zp_of(byte_t'(v0 + x)) : zp_of(v0);
  assign wide_ptr         = {v1, v0};
  assign two_byte_operand = mode inside {MD_ABS, MD_ABSX, MD_ABSY, MD_IND};

  always_comb begin
    case (step)
      step_t'(0): rd_addr = pc;
      step_t'(1): rd_addr = two_byte_operand ? pc + addr_t'(1) : zp_ptr;
      step_t'(2): rd_addr = (mode == MD_IND) ? wide_ptr : zp_ptr + addr_t'(1);
      step_t'(3): rd_addr = same_page_next(wide_ptr);
      default:    rd_addr = pc;
    endcase
  end
endmodule

// File: rtl/eag_resolve.sv
`timescale 1ns/1ps
module eag_resolve
  import eag_pkg::*;
(
  input  logic [3:0] mode,
  input  addr_t      pc,
  input  byte_t      x,
  input  byte_t      y,
  input  byte_t      v0,
  input  byte_t      v1,
  input  byte_t      v2,
  input  byte_t      v3,
  input  logic [2:0] cond,
  input  logic [3:0] flags,
  output eag_res_t   res
);
  addr_t adv1, adv2, br_target;
  logic  br_taken;

  assign adv1      = pc + addr_t'(1);
  assign adv2      = pc + addr_t'(2);
  assign br_target = adv1 + sign_widen(v0);
  assign br_taken  = branch_ok(cond, flags);

  always_comb begin
    res.taken = 1'b0;
    res.pc    = adv1;
    case (mode)
      MD_IMM:   res.ea = pc;
      MD_ZP:    res.ea = zp_of(v0);
      MD_ZPX:   res.ea = zp_of(byte_t'(v0 + x));
      MD_ZPY:   res.ea = zp_of(byte_t'(v0 + y));
      MD_ABS:  begin res.ea = {v1, v0};             res.pc = adv2; end
      MD_ABSX: begin res.ea = {v1, v0} + widen(x);  res.pc = adv2; end
      MD_ABSY: begin res.ea = {v1, v0} + widen(y);  res.pc = adv2; end
      MD_IND:  begin res.ea = {v3, v2};             res.pc = adv2; end
      MD_PREX:  res.ea = {v2, v1};
      MD_POSTY: res.ea = {v2, v1} + widen(y);
      MD_REL: begin
        res.ea    = br_target;
        res.taken = br_taken;
        res.pc    = br_taken ? br_target : adv1;
      end
      default: begin
        res.ea = pc;
        res.pc = pc;
      end
    endcase
  end
endmodule

// File: rtl/eff_addr_gen.sv
`timescale 1ns/1ps
module eff_addr_gen
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [3:0]  mode_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  x_i,
  input  logic [7:0]  y_i,
  input  logic [2:0]  cond_i,
  input  logic [3:0]  flags_i,
  output logic        mem_rd_o,
  output logic [15:0] mem_addr_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        busy_o,
  output logic        valid_o,
  output logic [15:0] ea_o,
  output logic [15:0] pc_o,
  output logic        taken_o
);
  logic       busy_q, valid_q;
  step_t      step_q;
  logic [3:0] mode_q;
  addr_t      pc_q;
  byte_t      x_q, y_q;
  logic [2:0] cond_q;
  logic [3:0] flags_q;
  byte_t      byte_q [MAX_RD];
  byte_t      view   [MAX_RD];
  eag_res_t   res_c, res_q;

  // named internal events
  step_t n_reads;
  logic  zp_mode, unused_mode;
  logic  accept, final_step, rd_fire;
  addr_t rd_addr;

  eag_read_plan u_plan (
    .mode(mode_q), .n_reads(n_reads), .zp_mode(zp_mode), .unused_mode(unused_mode)
  );

  assign accept     = start_i && !busy_q;
  assign final_step = busy_q && (step_q == n_reads);
  assign rd_fire    = busy_q && !final_step;

  // the byte requested last cycle is taken straight from the port
  always_comb begin
    for (int k = 0; k < MAX_RD; k++)
      view[k] = (busy_q && step_q == step_t'(k + 1)) ? mem_rdata_i : byte_q[k];
  end

  eag_fetch_addr u_fetch (
    .mode(mode_q), .step(step_q), .pc(pc_q), .x(x_q),
    .v0(view[0]), .v1(view[1]), .rd_addr(rd_addr)
  );

  eag_resolve u_resolve (
    .mode(mode_q), .pc(pc_q), .x(x_q), .y(y_q),
    .v0(view[0]), .v1(view[1]), .v2(view[2]), .v3(view[3]),
    .cond(cond_q), .flags(flags_q), .res(res_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      step_q  <= '0;
      mode_q  <= '0;
      pc_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      cond_q  <= '0;
      flags_q <= '0;
      res_q   <= '0;
      for (int k = 0; k < MAX_RD; k++) byte_q[k] <= '0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        step_q  <= '0;
        mode_q  <= mode_i;
        pc_q    <= pc_i;
        x_q     <= x_i;
        y_q     <= y_i;
        cond_q  <= cond_i;
        flags_q <= flags_i;
      end else if (busy_q) begin
        for (int k = 0; k < MAX_RD; k++) byte_q[k] <= view[k];
        if (final_step) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
          res_q   <= res_c;
        end else begin
          step_q <= step_q + step_t'(1);
        end
      end
    end
  end

  assign mem_rd_o   = rd_fire;
  assign mem_addr_o = rd_addr;
  assign busy_o     = busy_q;
  assign valid_o    = valid_q;
  assign ea_o       = res_q.ea;
  assign pc_o       = res_q.pc;
  assign taken_o    = res_q.taken;

  // R2: result strobe lasts a single cycle
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R2: a request in flight keeps its captured mode and PC
  assert_hold_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(mode_q) && $stable(pc_q)));

  // R11: reads only happen inside a request
  assert_read_in_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> busy_o);

  // R4: page-zero results never leave page zero
  assert_zp_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && zp_mode) |-> (ea_o[15:8] == 8'h00));

  // R6: the second pointer read stays in the page of the first
  assert_ind_same_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mode_q == MD_IND && step_q == step_t'(3))
      |-> (mem_addr_o[15:8] == $past(mem_addr_o[15:8])));

  // R10: unused codes leave the PC where it was
  assert_unused_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && unused_mode) |-> (pc_o == ea_o));
endmodule

// File: tb/sim_eff_addr_gen.sv
`timescale 1ns/1ps
module sim_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  x_i = '0, y_i = '0;
  logic [2:0]  cond_i = '0;
  logic [3:0]  flags_i = '0;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        busy_o, valid_o, taken_o;
  logic [15:0] ea_o, pc_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [7:0] memo [int];

  always #5 clk = ~clk;

  eff_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .pc_i(pc_i),
    .x_i(x_i), .y_i(y_i), .cond_i(cond_i), .flags_i(flags_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .valid_o(valid_o), .ea_o(ea_o), .pc_o(pc_o), .taken_o(taken_o)
  );

  function automatic int mem_at(int a);
    int w = a & 'hFFFF;
    if (memo.exists(w)) return int'(memo[w]);
    return ((w * 37) ^ ((w >> 8) * 11) ^ 'h5A) & 'hFF;
  endfunction

  task automatic poke(int a, int v);
    memo[a & 'hFFFF] = 8'(v);
  endtask

  // registered memory: data one cycle after the request
  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= 8'(mem_at(int'(mem_addr_o)));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int m);
    case (m)
      0: return "R3";
      1, 2, 3: return "R4";
      4, 5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R8";
      10: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model plus cycle-by-cycle comparison; called at a negedge
  task automatic run(int m, int p, int xi, int yi, int cs, int fl, bit poke_busy);
    int ra[$];
    int e_ea, e_pc, e_tk, op0, op1, base, z, adv, off, fsel;
    string rq = req_of(m);
    e_tk = 0;
    op0 = mem_at(p);
    op1 = mem_at(p + 1);
    base = op1 * 256 + op0;
    case (m)
      0: begin e_ea = p; e_pc = p + 1; end
      1: begin ra = '{p}; e_ea = op0; e_pc = p + 1; end
      2: begin ra = '{p}; e_ea = (op0 + xi) % 256; e_pc = p + 1; end
      3: begin ra = '{p}; e_ea = (op0 + yi) % 256; e_pc = p + 1; end
      4: begin ra = '{p, (p + 1) % 65536}; e_ea = base; e_pc = p + 2; end
      5: begin ra = '{p, (p + 1) % 65536}; e_ea = (base + xi) % 65536; e_pc = p + 2; end
      6: begin ra = '{p, (p + 1) % 65536}; e_ea = (base + yi) % 65536; e_pc = p + 2; end
      7: begin
        ra = '{p, (p + 1) % 65536, base, (base / 256) * 256 + ((base % 256) + 1) % 256};
        e_ea = mem_at(ra[3]) * 256 + mem_at(base);
        e_pc = p + 2;
      end
      8: begin
        z = (op0 + xi) % 256;
        ra = '{p, z, z + 1};
        e_ea = mem_at(z + 1) * 256 + mem_at(z);
        e_pc = p + 1;
      end
      9: begin
        ra = '{p, op0, op0 + 1};
        e_ea = (mem_at(op0 + 1) * 256 + mem_at(op0) + yi) % 65536;
        e_pc = p + 1;
      end
      10: begin
        ra = '{p};
        adv = (p + 1) % 65536;
        off = (op0 > 127) ? op0 - 256 : op0;
        e_ea = (adv + off + 65536) % 65536;
        fsel = (fl >> (3 - (cs >> 1))) & 1;
        e_tk = (fsel == (cs & 1)) ? 1 : 0;
        e_pc = e_tk ? e_ea : adv;
      end
      default: begin e_ea = p; e_pc = p; end
    endcase
    e_pc = e_pc % 65536;

    start_i = 1'b1; mode_i = 4'(m); pc_i = 16'(p); x_i = 8'(xi); y_i = 8'(yi);
    cond_i = 3'(cs); flags_i = 4'(fl);
    @(negedge clk);
    // R2: a second start while busy must be ignored, and input changes too
    start_i = poke_busy;
    if (poke_busy) begin
      mode_i = 4'd0; pc_i = 16'hDEAD; x_i = ~x_i; y_i = ~y_i; flags_i = ~flags_i;
    end
    chk("R2", "busy", int'(busy_o), 1);
    foreach (ra[k]) begin
      chk("R11", "rd", int'(mem_rd_o), 1);
      chk("R11", "addr", int'(mem_addr_o), ra[k]);
      chk("R2", "early valid", int'(valid_o), 0);
      @(negedge clk);
      start_i = 1'b0;
    end
    chk("R2", "rd in final cycle", int'(mem_rd_o), 0);
    chk("R2", "early valid", int'(valid_o), 0);
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "valid", int'(valid_o), 1);
    chk(rq, "ea", int'(ea_o), e_ea);
    chk(rq, "pc", int'(pc_o), e_pc);
    chk(m == 10 ? "R9" : rq, "taken", int'(taken_o), e_tk);
    chk("R2", "idle at valid", int'(busy_o), 0);
    @(negedge clk);
    chk("R2", "valid single", int'(valid_o), 0);
    chk("R2", "no re-accept", int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "valid", int'(valid_o), 0);
    chk("R1", "rd", int'(mem_rd_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 immediate
    run(0, 'h1234, 0, 0, 0, 0, 0);
    run(0, 'hFFFF, 0, 0, 0, 0, 0);
    // R4 page zero, with and without index wrap
    poke('h0200, 'h33);
    run(1, 'h0200, 0, 0, 0, 0, 0);
    poke('h0210, 'hF0);
    run(2, 'h0210, 'h20, 0, 0, 0, 0);
    run(3, 'h0210, 0, 'h05, 0, 0, 0);
    // R5 direct, 16-bit wrap
    poke('h0300, 'hF0); poke('h0301, 'hFF);
    run(4, 'h0300, 0, 0, 0, 0, 0);
    run(5, 'h0300, 'h20, 0, 0, 0, 0);
    run(6, 'h0300, 0, 'h0F, 0, 0, 0);
    run(5, 'h0320, 'h7F, 0, 0, 0, 0);
    // R6 pointer jump: page wrap and ordinary pointer
    poke('h0400, 'hFF); poke('h0401, 'h30);
    poke('h30FF, 'h34); poke('h3000, 'h12); poke('h3100, 'h99);
    run(7, 'h0400, 0, 0, 0, 0, 0);
    poke('h0410, 'h20); poke('h0411, 'h50); poke('h5020, 'h78); poke('h5021, 'h56);
    run(7, 'h0410, 0, 0, 0, 0, 0);
    // R7 pointer before index: Z at 0xFF carries to 0x0100; index wraps in page
    poke('h0500, 'hFA); poke('h00FF, 'hCD); poke('h0100, 'hAB); poke('h0000, 'h11);
    run(8, 'h0500, 'h05, 0, 0, 0, 0);
    poke('h0510, 'hF0);
    run(8, 'h0510, 'h20, 0, 0, 0, 0);
    // R8 pointer after index, 16-bit wrap
    poke('h0600, 'h40); poke('h0040, 'hF0); poke('h0041, 'hFF);
    run(9, 'h0600, 0, 'h20, 0, 0, 0);
    run(9, 'h0600, 0, 'h03, 0, 0, 0);
    // R9 relative: forward and backward offsets, every condition both ways
    poke('h0700, 'h10); poke('h0710, 'h80);
    for (int c = 0; c < 8; c++) begin
      run(10, 'h0700, 0, 0, c, 'hA, 0);
      run(10, 'h0710, 0, 0, c, 'h5, 0);
    end
    poke('hFFFF, 'h05);
    run(10, 'hFFFF, 0, 0, 1, 'h8, 0);
    // R10 unused codes
    for (int m = 11; m < 16; m++) run(m, 'h4321 + m, 1, 2, 0, 0, 0);
    // R2 start while busy is ignored
    run(7, 'h0400, 0, 0, 0, 0, 1);
    run(0, 'h0800, 0, 0, 0, 0, 1);
    run(9, 'h0600, 0, 'h20, 0, 0, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule